// File: doc/BRIEF.md
# Channel-List Acquisition Scan Sequencer

This block walks an analog front end through a programmable table of conversion entries. Each of the sixteen table slots names a multiplexer channel, a two-bit gain code and a unipolar flag. A scan opens on a scan-rate pulse, or on an external trigger when the control register selects it. Each conversion inside the scan is launched by a conversion-rate pulse. The block then raises a one-cycle start strobe towards the converter, with the slot's settings alongside, and waits for the converter's done signal.

Every returned sample goes into a small result FIFO that the host drains through a register port. Status reports a busy converter, end-of-scan, end-of-conversion, overflow, and FIFO full and empty. A single interrupt line combines the end-of-conversion and end-of-scan events, each with its own enable bit. A scan runs from a programmable first slot to a programmable last slot, counting up modulo 16. Once the last slot is done, the position returns to the first slot and waits for the next scan-start event.

Top module: `scan_sequencer`

## Requirements
- R1: A host write to offset 0x6 stores a table slot. Bits [11:8] select the slot, bit 7 is the unipolar flag, bits [5:4] the gain and bits [3:0] the channel. A launch drives those fields of the current slot on the converter outputs, together with a one-cycle start strobe.
- R2: A host write to offset 0x0 loads the control register. Bits [3:0] give the first slot, bits [11:8] the last slot, bit 12 the run gate and bit 15 selects the external trigger. Every such write stops any scan and returns the position to the first slot.
- R3: With mode bit 3 clear (mode register at offset 0xE), each scan converts only the first slot and then ends.
- R4: With mode bit 3 set, a scan converts the first slot through the last slot in increasing order, modulo 16. After the last slot it waits for a new scan-start event, and conversion pulses in that interval launch nothing.
- R5: A conversion pulse that arrives while a conversion is busy is ignored.
- R6: Status bit 15 is set from the launch until the converter reports done.
- R7: Status bit 13 (end of scan) sets when the last conversion of a scan completes. Status bit 4 (end of conversion) sets on every completion. A status read at offset 0x2 clears both. The interrupt equals (mode bit 0 AND bit 4) OR (mode bit 1 AND bit 13).
- R8: Samples are read in arrival order at offset 0x0, one per read. Status bit 1 is FIFO empty and bit 2 is FIFO full.
- R9: A sample that completes while the FIFO is full is dropped, and status bit 3 (overflow) latches.
- R10: A host read of offset 0xC empties the FIFO and clears the overflow flag.
- R11: With control bit 15 set, only the external trigger starts a scan. With it clear, only the scan-rate pulse starts a scan.
- R12: After a write of zero to control, the busy bit is clear, a converter done signal stores nothing, and neither pulse input launches a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe; read side effects occur at the clock edge |
| host_addr | input | 4 | Host register offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for the current offset |
| conv_tick | input | 1 | Conversion-rate pulse |
| scan_tick | input | 1 | Scan-rate pulse |
| ext_trig | input | 1 | External scan trigger pulse |
| conv_start | output | 1 | One-cycle converter start strobe |
| conv_chan | output | 4 | Multiplexer channel for the launched conversion |
| conv_gain | output | 2 | Gain code for the launched conversion |
| conv_unipolar | output | 1 | Unipolar flag for the launched conversion |
| conv_done | input | 1 | Converter result valid |
| conv_data | input | DATA_W | Converter result |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions cover several properties on every cycle. A busy converter never gets a second start strobe. A full FIFO stays full unless it is popped or cleared. Full and empty never hold together. End-of-scan only rises on an accepted completion. A zero control write always leaves the block idle.

Some behaviour only the bench scenarios can show. These are the slot order across every first slot and scan length, including the wrap past slot 15, and the restart at the first slot on a second scan. They also cover the single-slot mode, trigger selection, the interrupt enables, dropped samples and the FIFO clear through the unrelated address, all checked against values the bench computes.

// File: rtl/scan_sequencer.sv
`timescale 1ns/1ps
module scan_sequencer #(
  parameter int LIST_DEPTH = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int DATA_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [3:0]        host_addr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  input  logic              conv_tick,
  input  logic              scan_tick,
  input  logic              ext_trig,
  output logic              conv_start,
  output logic [3:0]        conv_chan,
  output logic [1:0]        conv_gain,
  output logic              conv_unipolar,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              irq
);
  localparam int IDX_W = $clog2(LIST_DEPTH);
  localparam int FP_W  = $clog2(FIFO_DEPTH);
  localparam logic [3:0] A_DATA = 4'h0, A_STAT = 4'h2, A_LIST = 4'h6,
                         A_FCLR = 4'hC, A_MODE = 4'hE;

  logic [6:0]        list_q [LIST_DEPTH];
  logic [DATA_W-1:0] fifo_q [FIFO_DEPTH];
  logic [FP_W:0]     wp_q, rp_q;
  logic [IDX_W-1:0]  first_q, last_q, pos_q;
  logic              gate_q, ext_sel_q;
  logic              multi_q, eos_en_q, eoc_en_q;
  logic              scanning_q, busy_q, eos_q, eoc_q, ovf_q;

  wire ctrl_wr = host_wr && host_addr == A_DATA;
  wire list_wr = host_wr && host_addr == A_LIST;
  wire mode_wr = host_wr && host_addr == A_MODE;
  wire pop_req = host_rd && host_addr == A_DATA;
  wire stat_rd = host_rd && host_addr == A_STAT;
  wire fclr    = host_rd && host_addr == A_FCLR;

  wire [FP_W:0] fill = wp_q - rp_q;
  wire full  = fill == (FP_W+1)'(FIFO_DEPTH);
  wire empty = fill == '0;

  wire scan_evt  = gate_q && !scanning_q && !ctrl_wr && (ext_sel_q ? ext_trig : scan_tick);
  wire launch    = gate_q && scanning_q && !busy_q && conv_tick && !ctrl_wr;
  wire done_fire = conv_done && busy_q && !ctrl_wr;
  wire at_last   = !multi_q || pos_q == last_q;
  wire push_fire = done_fire && !full && !fclr;
  wire drop      = done_fire && full && !fclr;
  wire pop_fire  = pop_req && !empty && !fclr;

  logic unused_bits;
  assign unused_bits = ^{host_wdata[14:13], host_wdata[6]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LIST_DEPTH; i++) list_q[i] <= '0;
    end else if (list_wr) begin
      list_q[host_wdata[8 +: IDX_W]] <= {host_wdata[7], host_wdata[5:4], host_wdata[3:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (push_fire) fifo_q[wp_q[FP_W-1:0]] <= conv_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
      ovf_q <= 1'b0;
    end else if (fclr) begin
      wp_q <= '0;
      rp_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (push_fire) wp_q <= wp_q + 1'b1;
      if (pop_fire)  rp_q <= rp_q + 1'b1;
      if (drop)      ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {multi_q, eos_en_q, eoc_en_q} <= '0;
    end else if (mode_wr) begin
      {multi_q, eos_en_q, eoc_en_q} <= {host_wdata[3], host_wdata[1], host_wdata[0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0; last_q <= '0; pos_q <= '0;
      gate_q <= 1'b0; ext_sel_q <= 1'b0;
      scanning_q <= 1'b0; busy_q <= 1'b0;
      conv_start <= 1'b0;
      {conv_unipolar, conv_gain, conv_chan} <= '0;
    end else begin
      conv_start <= launch;
      if (ctrl_wr) begin
        first_q    <= host_wdata[0 +: IDX_W];
        last_q     <= host_wdata[8 +: IDX_W];
        pos_q      <= host_wdata[0 +: IDX_W];
        gate_q     <= host_wdata[12];
        ext_sel_q  <= host_wdata[15];
        scanning_q <= 1'b0;
        busy_q     <= 1'b0;
      end else begin
        if (scan_evt) scanning_q <= 1'b1;
        if (launch) begin
          busy_q <= 1'b1;
          {conv_unipolar, conv_gain, conv_chan} <= list_q[pos_q];
        end
        if (done_fire) begin
          busy_q <= 1'b0;
          if (at_last) begin
            pos_q <= first_q;
            scanning_q <= 1'b0;
          end else begin
            pos_q <= pos_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eos_q <= 1'b0;
      eoc_q <= 1'b0;
    end else begin
      if (done_fire && at_last) eos_q <= 1'b1;
      else if (stat_rd)         eos_q <= 1'b0;
      if (done_fire)            eoc_q <= 1'b1;
      else if (stat_rd)         eoc_q <= 1'b0;
    end
  end

  wire [15:0] status = {busy_q, 1'b0, eos_q, 8'b0, eoc_q, ovf_q, full, empty, 1'b0};

  always_comb begin
    case (host_addr)
      A_DATA:  host_rdata = empty ? 16'h0 : 16'(fifo_q[rp_q[FP_W-1:0]]);
      A_STAT:  host_rdata = status;
      default: host_rdata = 16'h0;
    endcase
  end

  assign irq = (eoc_en_q && eoc_q) || (eos_en_q && eos_q);

  assert_busy_blocks_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !conv_start);
  assert_full_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop_fire && !fclr) |=> full);
  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  assert_eos_from_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eos_q) |-> $past(conv_done && busy_q));
  assert_zero_ctrl_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && host_wdata == 16'h0) |=> (!busy_q && !scanning_q && !conv_start));
endmodule

// File: tb/tb_scan_sequencer.sv
`timescale 1ns/1ps
module tb_scan_sequencer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 0, host_rd = 0;
  logic [3:0] host_addr = 0;
  logic [15:0] host_wdata = 0, host_rdata;
  logic conv_tick = 0, scan_tick = 0, ext_trig = 0, conv_done = 0;
  logic [15:0] conv_data = 0;
  logic conv_start, conv_unipolar, irq;
  logic [3:0] conv_chan;
  logic [1:0] conv_gain;

  int vec_n = 0, bad_n = 0, seq = 0;
  bit finished = 0;
  logic [15:0] model[$];

  always #2.5 clk = ~clk;

  scan_sequencer dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec_n++;
    if (act !== exp) begin
      bad_n++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] entry(input int i);
    entry = {1'((i / 3) % 2), 2'(i % 4), 4'((i * 5 + 3) % 16)};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); host_rd = 1; host_addr = a; #1 d = host_rdata;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic pulse_scan(); @(negedge clk); scan_tick = 1; @(negedge clk); scan_tick = 0; endtask
  task automatic pulse_ext();  @(negedge clk); ext_trig = 1;  @(negedge clk); ext_trig = 0;  endtask
  task automatic pulse_tick(); @(negedge clk); conv_tick = 1; @(negedge clk); conv_tick = 0; endtask

  task automatic finish_conv(input bit keep);
    logic [15:0] d;
    d = 16'(seq * 16'h0123 + 16'h0F0F);
    seq++;
    @(negedge clk); conv_done = 1; conv_data = d;
    @(negedge clk); conv_done = 0;
    if (keep) model.push_back(d);
  endtask

  task automatic do_conv(input int idx, input bit keep);
    pulse_tick();
    chk("R1 start strobe", conv_start, 1);
    chk("R1 slot fields", {conv_unipolar, conv_gain, conv_chan}, entry(idx));
    finish_conv(keep);
  endtask

  task automatic no_launch(input string req);
    pulse_tick();
    chk(req, conv_start, 0);
  endtask

  task automatic drain(input string req);
    logic [15:0] d;
    while (model.size() > 0) begin
      rd(4'h0, d);
      chk(req, d, model.pop_front());
    end
    rd(4'h2, d);
    chk("R8 empty after drain", d[1], 1);
  endtask

  function automatic logic [15:0] ctrl_word(input bit ext, input int first, input int last);
    ctrl_word = {ext, 2'b0, 1'b1, 4'(last), 4'b0, 4'(first)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad_n++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(4'h2, d);
    chk("R8 reset status", d, 16'h0002);
    chk("R7 reset irq", irq, 0);
    chk("R1 reset strobe", conv_start, 0);

    for (int i = 0; i < 16; i++) begin
      logic [6:0] e;
      e = entry(i);
      wr(4'h6, {4'b0, 4'(i), e[6], 1'b0, e[5:4], e[3:0]});
    end

    wr(4'hE, 16'h0008);
    for (int s = 0; s < 16; s++) begin
      for (int len = 1; len <= 4; len++) begin
        int passes;
        passes = (len == 3) ? 2 : 1;
        wr(4'h0, ctrl_word(0, s, (s + len - 1) % 16));
        for (int p = 0; p < passes; p++) begin
          pulse_scan();
          for (int k = 0; k < len; k++) do_conv((s + k) % 16, 1);
          rd(4'h2, d);
          chk("R7 end of scan", d[13], 1);
          chk("R4 idle after last slot", d[15], 0);
          if (len == 1) no_launch("R4 wait for scan start");
        end
        drain("R8 fifo order");
      end
    end

    wr(4'hE, 16'h0000);
    wr(4'h0, ctrl_word(0, 5, 9));
    pulse_scan();
    do_conv(5, 1);
    no_launch("R3 single slot ends scan");
    pulse_scan();
    do_conv(5, 1);
    drain("R3 fifo");

    wr(4'hE, 16'h0008);
    wr(4'h0, ctrl_word(0, 0, 1));
    pulse_scan();
    pulse_tick();
    chk("R1 launch slot 0", {conv_unipolar, conv_gain, conv_chan}, entry(0));
    rd(4'h2, d);
    chk("R6 busy set", d[15], 1);
    no_launch("R5 tick while busy");
    finish_conv(1);
    rd(4'h2, d);
    chk("R6 busy clear", d[15], 0);
    do_conv(1, 1);
    drain("R5 fifo");

    wr(4'hE, 16'h0009);
    wr(4'h0, ctrl_word(0, 2, 3));
    pulse_scan();
    do_conv(2, 1);
    chk("R7 eoc irq", irq, 1);
    rd(4'h2, d);
    chk("R7 eoc bit", d[4], 1);
    chk("R7 irq cleared by status read", irq, 0);
    do_conv(3, 1);
    chk("R7 eoc irq again", irq, 1);
    rd(4'h2, d);
    wr(4'hE, 16'h000A);
    pulse_scan();
    do_conv(2, 1);
    chk("R7 eos irq not yet", irq, 0);
    do_conv(3, 1);
    chk("R7 eos irq", irq, 1);
    rd(4'h2, d);
    chk("R7 eos irq cleared", irq, 0);
    drain("R7 fifo");

    wr(4'hE, 16'h0008);
    wr(4'h0, ctrl_word(0, 0, 15));
    pulse_scan();
    for (int k = 0; k < 8; k++) do_conv(k, 1);
    rd(4'h2, d);
    chk("R8 full flag", d[2], 1);
    chk("R9 no overflow yet", d[3], 0);
    do_conv(8, 0);
    rd(4'h2, d);
    chk("R9 overflow latched", d[3], 1);
    for (int k = 0; k < 8; k++) begin
      rd(4'h0, d);
      chk("R9 kept samples", d, model.pop_front());
    end
    rd(4'h2, d);
    chk("R9 overflow sticky", d[3], 1);
    do_conv(9, 0);
    rd(4'hC, d);
    rd(4'h2, d);
    chk("R10 fifo cleared", d[1], 1);
    chk("R10 overflow cleared", d[3], 0);

    pulse_tick();
    chk("R1 launch slot 10", conv_start, 1);
    wr(4'h0, 16'h0000);
    rd(4'h2, d);
    chk("R12 busy cleared", d[15], 0);
    finish_conv(0);
    rd(4'h2, d);
    chk("R12 done stores nothing", d[1], 1);
    pulse_scan();
    no_launch("R12 no launch after stop");

    wr(4'h0, ctrl_word(1, 4, 4));
    pulse_scan();
    no_launch("R11 scan pulse ignored when external selected");
    pulse_ext();
    do_conv(4, 1);
    wr(4'h0, ctrl_word(0, 4, 4));
    pulse_ext();
    no_launch("R11 external ignored when scan pulse selected");
    drain("R11 fifo");

    wr(4'h0, ctrl_word(0, 0, 3));
    pulse_scan();
    do_conv(0, 1);
    wr(4'h0, ctrl_word(0, 0, 3));
    no_launch("R2 control write stops scan");
    pulse_scan();
    do_conv(0, 1);
    drain("R2 fifo");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
    $finish;
  end
endmodule